// File: doc/BRIEF.md
# DMA Channel Shadow Reload Unit

This block keeps the source address and the remaining transfer count for a single DMA channel. Software can set up the next transaction's source address and transfer count while the current transaction is still moving data. Both values are held back and take effect together at the next transaction start. The address is parked in a shadow register. The count is parked in a reload register. When the start consumes the shadow value, the shadow register clears itself and its pending flag drops.

A single register-write port carries three kinds of write, picked by `wr_sel`:

| `wr_sel` | Target | Data used |
|---|---|---|
| 0 | Source address | `wr_data` |
| 1 | Count reload value | `wr_data[CNT_W-1:0]` |
| 2 | Shadow mode field | `wr_data[1:0]` |

The data mover signals each completed move on `xfer_done`. The block then advances the address by `ADDR_STEP` and lowers the count by one. When the count reaches zero, the block raises a one-cycle `txn_done`.

Top module: `dma_shadow_reload`

## Requirements
- R1: With the mode field equal to 01, a source-address write (`wr_sel`=0) stores the value in the shadow register and sets `shadow_pending`. `cur_addr` is left unchanged.
- R2: A `start` while `shadow_pending` is set copies the shadow address into `cur_addr`. The new value is visible in the cycle after the start.
- R3: A `start` loads the count reload value into `rem_count` in the cycle after the start.
- R4: While `busy` is high, each `xfer_done` lowers `rem_count` by one, down to zero.
- R5: While `busy` is high, each `xfer_done` raises `cur_addr` by `ADDR_STEP`, which defaults to 1.
- R6: Once a start has consumed the shadow value, `shadow_addr` reads zero and `shadow_pending` is low.
- R7: Writing the shadow address or the reload count during a running transaction leaves that transaction's address and count sequence unchanged.
- R8: The transfer that brings `rem_count` to zero raises `txn_done` for exactly one cycle and clears `busy`. Later `xfer_done` pulses leave the count and the address unchanged until the next `start`.
- R9: A `start` with no pending shadow value leaves `cur_addr` at its current value.
- R10: With any mode field value other than 01, a source-address write updates `cur_addr` directly in the next cycle and does not touch the shadow register.
- R11: When a source-address write and a `start` fall in the same cycle, the start uses the values held before the write. The written address goes to the shadow register with `shadow_pending` set, whatever the mode.
- R12: After reset, all outputs are zero, and the mode field is 00, so the channel is in direct-write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 source address, 1 count reload, 2 mode field |
| wr_data | input | ADDR_W | Write data |
| start | input | 1 | Begin a new transaction |
| xfer_done | input | 1 | One data move completed |
| cur_addr | output | ADDR_W | Active source address |
| rem_count | output | CNT_W | Remaining transfer count |
| shadow_addr | output | ADDR_W | Shadow source address |
| shadow_pending | output | 1 | Shadow register holds a value not yet used |
| busy | output | 1 | A transaction is running |
| txn_done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The hardest case to reach is a `start` and a source-address write in the same clock cycle. Here the start must swap in the old shadow state, while the new address lands in the shadow register. The bench drives both inputs in one cycle in the middle of a running transaction, after a transfer has already moved the address. This makes "continued from the current address" distinguishable from "reloaded". The bench also writes the reload register and the shadow address between two transfers of a live transaction. It then checks that the running sequence goes on unchanged, and that both values appear only at the following start.

// File: rtl/dma_shr_pkg.sv
// Package: shared encodings for the DMA channel shadow reload unit.
// Assumes a 2-bit write selector and a 2-bit shadow mode field.
package dma_shr_pkg;
    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_MODE = 2'd2
    } reg_sel_e;

    localparam logic [1:0] MODE_DIRECT = 2'b00;
    localparam logic [1:0] MODE_SHADOW = 2'b01;
endpackage

// File: rtl/shr_shadow_store.sv
// Module: shadow source-address register with a pending flag.
// A load stores a value and marks it pending. A consume clears both.
// A load in the same cycle as a consume wins, so a coinciding write
// stays buffered for the following start.
module shr_shadow_store #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          consume,
    output logic [AW-1:0] shadow_q,
    output logic          pending_q
);
    // Hold, replace or clear the buffered address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            pending_q <= 1'b0;
        end else if (load) begin
            shadow_q  <= load_val;
            pending_q <= 1'b1;
        end else if (consume) begin
            shadow_q  <= '0;
            pending_q <= 1'b0;
        end
    end
endmodule

// File: rtl/shr_addr_track.sv
// Module: active source-address register.
// A load takes priority over a step. A step adds STEP, wrapping at AW bits.
module shr_addr_track #(
    parameter int AW   = 32,
    parameter int STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    output logic [AW-1:0] addr_q
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Load a new address or advance by one step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load_en)
            addr_q <= load_val;
        else if (step_en)
            addr_q <= addr_q + STEP_V;
    end
endmodule

// File: rtl/shr_count_track.sv
// Module: active transfer count, busy flag and done pulse.
// A start loads the reload value. A step is ignored unless busy.
// A start with a zero reload leaves the channel idle with no pulse.
module shr_count_track #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] reload,
    input  logic          step,
    output logic [CW-1:0] count_q,
    output logic          busy_q,
    output logic          done_q
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Load on start; otherwise count down while busy and flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                count_q <= reload;
                busy_q  <= (reload != '0);
            end else if (step && busy_q) begin
                count_q <= count_q - ONE;
                if (count_q == ONE) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma_shadow_reload.sv
// Module: DMA channel shadow reload unit (top).
// Decodes register writes, holds the mode field and the count reload
// value, and steers the shadow, address and count submodules.
// Assumes start and xfer_done are single-cycle strobes from the
// channel's sequencer. When both fall in one cycle, start wins.
module dma_shadow_reload #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 14,
    parameter int ADDR_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              start,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  rem_count,
    output logic [ADDR_W-1:0] shadow_addr,
    output logic              shadow_pending,
    output logic              busy,
    output logic              txn_done
);
    import dma_shr_pkg::*;

    logic [1:0]        mode_q;
    logic [CNT_W-1:0]  reload_q;
    logic              wr_src, wr_cnt, wr_mode;
    logic              shadow_load, direct_load;
    logic              addr_load_en;
    logic [ADDR_W-1:0] addr_load_val;
    logic              addr_step;

    // Decode the write target and route source-address writes.
    always_comb begin
        wr_src      = wr_en && (wr_sel == SEL_SRC);
        wr_cnt      = wr_en && (wr_sel == SEL_CNT);
        wr_mode     = wr_en && (wr_sel == SEL_MODE);
        shadow_load = wr_src && (start || (mode_q == MODE_SHADOW));
        direct_load = wr_src && !start && (mode_q != MODE_SHADOW);
    end

    // Choose what the active address register takes this cycle.
    always_comb begin
        addr_load_en  = start ? shadow_pending : direct_load;
        addr_load_val = start ? shadow_addr : wr_data;
        addr_step     = xfer_done && busy && !start;
    end

    // Hold the mode field and the count reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_DIRECT;
            reload_q <= '0;
        end else begin
            if (wr_mode) mode_q   <= wr_data[1:0];
            if (wr_cnt)  reload_q <= wr_data[CNT_W-1:0];
        end
    end

    shr_shadow_store #(.AW(ADDR_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shadow_load),
        .load_val  (wr_data),
        .consume   (start),
        .shadow_q  (shadow_addr),
        .pending_q (shadow_pending)
    );

    shr_addr_track #(.AW(ADDR_W), .STEP(ADDR_STEP)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (addr_load_en),
        .load_val (addr_load_val),
        .step_en  (addr_step),
        .addr_q   (cur_addr)
    );

    shr_count_track #(.CW(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .reload  (reload_q),
        .step    (xfer_done),
        .count_q (rem_count),
        .busy_q  (busy),
        .done_q  (txn_done)
    );
endmodule

// File: rtl/shr_checker.sv
// Module: property checker for dma_shadow_reload, attached by bind.
// Observes the ports plus the mode and reload registers.
module shr_checker #(
    parameter int AW   = 32,
    parameter int CW   = 14,
    parameter int STEP = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic          start,
    input logic          xfer_done,
    input logic [AW-1:0] cur_addr,
    input logic [CW-1:0] rem_count,
    input logic [AW-1:0] shadow_addr,
    input logic          shadow_pending,
    input logic          busy,
    input logic          txn_done,
    input logic [1:0]    mode_q,
    input logic [CW-1:0] reload_q
);
    logic src_wr;
    assign src_wr = wr_en && (wr_sel == 2'd0);

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        src_wr && mode_q == 2'b01 && !start && !(busy && xfer_done)
        |=> cur_addr == $past(cur_addr) && shadow_pending); // R1
    AST_SHADOW_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        start && shadow_pending |=> cur_addr == $past(shadow_addr)); // R2
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> rem_count == $past(reload_q)); // R3
    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        busy && xfer_done && !start
        |=> rem_count == CW'($past(rem_count) - CW'(1))); // R4
    AST_ADDR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        busy && xfer_done && !start && !(src_wr && mode_q != 2'b01)
        |=> cur_addr == AW'($past(cur_addr) + AW'(STEP))); // R5
    AST_SHADOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start && shadow_pending && !src_wr
        |=> shadow_addr == '0 && !shadow_pending); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> !txn_done); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(rem_count)); // R8
    AST_COLLIDE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        start && src_wr |=> shadow_pending); // R11
endmodule

bind dma_shadow_reload shr_checker #(
    .AW(ADDR_W), .CW(CNT_W), .STEP(ADDR_STEP)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .start          (start),
    .xfer_done      (xfer_done),
    .cur_addr       (cur_addr),
    .rem_count      (rem_count),
    .shadow_addr    (shadow_addr),
    .shadow_pending (shadow_pending),
    .busy           (busy),
    .txn_done       (txn_done),
    .mode_q         (mode_q),
    .reload_q       (reload_q)
);

// File: tb/sim_dma_shadow_reload.sv
// Directed bench for dma_shadow_reload: one task per scenario.
module sim_dma_shadow_reload;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic        xfer_done = 1'b0;
    logic [31:0] cur_addr;
    logic [13:0] rem_count;
    logic [31:0] shadow_addr;
    logic        shadow_pending, busy, txn_done;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_shadow_reload u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .start(start), .xfer_done(xfer_done),
        .cur_addr(cur_addr), .rem_count(rem_count), .shadow_addr(shadow_addr),
        .shadow_pending(shadow_pending), .busy(busy), .txn_done(txn_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock with the given strobes; returns at the next falling edge.
    task automatic cyc(input logic s, input logic x, input logic w,
                       input logic [1:0] sel, input logic [31:0] d);
        start = s; xfer_done = x; wr_en = w; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        start = 0; xfer_done = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    task automatic t_reset;
        chk("R12 addr", cur_addr, 0);
        chk("R12 count", {18'd0, rem_count}, 0);
        chk("R12 shadow", shadow_addr, 0);
        chk("R12 flags", {29'd0, shadow_pending, busy, txn_done}, 0);
    endtask

    task automatic t_direct;
        cyc(0, 0, 1, 2'd0, 32'h1000);
        chk("R10 direct addr", cur_addr, 32'h1000);
        chk("R10 no pending", {31'd0, shadow_pending}, 0);
    endtask

    task automatic t_run;
        cyc(0, 0, 1, 2'd1, 32'd3);
        cyc(1, 0, 0, 2'd0, 0);
        chk("R3 start count", {18'd0, rem_count}, 3);
        chk("R3 busy", {31'd0, busy}, 1);
        for (int i = 1; i <= 3; i++) begin
            cyc(0, 1, 0, 2'd0, 0);
            chk("R4 count", {18'd0, rem_count}, 32'(3 - i));
            chk("R5 addr", cur_addr, 32'h1000 + 32'(i));
        end
        chk("R8 done pulse", {31'd0, txn_done}, 1);
        chk("R8 busy clear", {31'd0, busy}, 0);
        cyc(0, 0, 0, 2'd0, 0);
        chk("R8 done one cycle", {31'd0, txn_done}, 0);
        cyc(0, 1, 0, 2'd0, 0);
        chk("R8 ignored count", {18'd0, rem_count}, 0);
        chk("R8 ignored addr", cur_addr, 32'h1003);
    endtask

    task automatic t_shadow;
        cyc(0, 0, 1, 2'd2, 32'h1);
        cyc(0, 0, 1, 2'd1, 32'd2);
        cyc(1, 0, 0, 2'd0, 0);
        chk("R9 no pending keeps addr", cur_addr, 32'h1003);
        cyc(0, 0, 1, 2'd0, 32'h2000);
        chk("R1 active unchanged", cur_addr, 32'h1003);
        chk("R1 shadow stored", shadow_addr, 32'h2000);
        chk("R1 pending", {31'd0, shadow_pending}, 1);
        cyc(0, 0, 1, 2'd1, 32'd5);
        chk("R7 count unchanged", {18'd0, rem_count}, 2);
        cyc(0, 1, 0, 2'd0, 0);
        chk("R7 addr seq", cur_addr, 32'h1004);
        chk("R7 count seq", {18'd0, rem_count}, 1);
        cyc(0, 1, 0, 2'd0, 0);
        chk("R7 final addr", cur_addr, 32'h1005);
        chk("R8 done", {31'd0, txn_done}, 1);
        cyc(1, 0, 0, 2'd0, 0);
        chk("R2 shadow copied", cur_addr, 32'h2000);
        chk("R3 reload copied", {18'd0, rem_count}, 5);
        chk("R6 shadow zero", shadow_addr, 0);
        chk("R6 pending clear", {31'd0, shadow_pending}, 0);
    endtask

    task automatic t_collide;
        cyc(0, 1, 0, 2'd0, 0);
        chk("R5 step", cur_addr, 32'h2001);
        cyc(1, 0, 1, 2'd0, 32'h3000);
        chk("R11 addr from old state", cur_addr, 32'h2001);
        chk("R11 count reloaded", {18'd0, rem_count}, 5);
        chk("R11 write buffered", shadow_addr, 32'h3000);
        chk("R11 pending", {31'd0, shadow_pending}, 1);
        cyc(1, 0, 0, 2'd0, 0);
        chk("R2 second swap", cur_addr, 32'h3000);
        chk("R6 cleared again", {31'd0, shadow_pending}, 0);
        cyc(0, 0, 1, 2'd2, 32'h2);
        cyc(0, 0, 1, 2'd0, 32'h4000);
        chk("R10 mode 10 direct", cur_addr, 32'h4000);
        chk("R10 shadow untouched", shadow_addr, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_run();
        t_shadow();
        t_collide();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule